// File: doc/BRIEF.md
# Memory access watchdog counter

This block supervises accesses to an attached message memory and raises a flag when the memory fails to answer in time. Each access is announced by a one-cycle start pulse. The memory reports completion by pulsing a ready input. A programmable reload value sets the timeout length in clock cycles. While an access is outstanding, a down-counter runs from the reload value. If it reaches zero before ready arrives, it stops there and a sticky timeout flag is set. Software clears the flag by writing a one.

The live counter value and the flag are plain status outputs. The block has no data stream, so none of its pins use a valid/ready handshake. The `mem_ready` input is a completion pulse from the memory, not a back-pressure signal. The counter runs on the peripheral bus clock. A reload value of zero turns the watchdog off.

Top module: `mem_access_wdog`

## Requirements
- R1: After reset the count output is 0, the timeout flag is 0 and no access is open.
- R2: With a nonzero reload value, a start pulse sets the count to the reload value on the next clock and opens an access. This also applies when the count is frozen at zero.
- R3: A ready pulse sets the count to the reload value on the next clock and closes the open access.
- R4: While an access is open, the count is above zero and neither start nor ready is present, the count falls by exactly one per clock.
- R5: At zero the count stays at zero and never wraps until a start or ready arrives.
- R6: The timeout flag is set on the clock at which an open access's count moves from 1 to 0. With no ready, this is exactly reload-value clocks after the start edge.
- R7: Once set, the timeout flag stays set as long as no clear is written.
- R8: A clear pulse (`flag_clr` = 1) clears the flag on the next clock. A value of 0 on `flag_clr` has no effect.
- R9: When the flag is set and cleared in the same cycle, the set wins and the flag remains 1.
- R10: When start and ready arrive together, start wins: the count loads the reload value and the access stays open, so counting continues.
- R11: A reload value of 0 forces the count to 0, opens no access and never sets the flag.
- R12: With no access open and neither start nor ready present, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_reload | input | CNT_W | Timeout length in clocks; 0 disables |
| acc_start | input | 1 | One-cycle pulse: a memory access begins |
| mem_ready | input | 1 | One-cycle pulse: the memory completed the access |
| flag_clr | input | 1 | Write-1-to-clear of the timeout flag |
| count_val | output | CNT_W | Live counter value |
| timeout_flag | output | 1 | Sticky timeout indication |

## Verification
Two pairs of functions can land in the same cycle. The first pair is expiry and software clear: the count's step from 1 to 0 coincides with a clear write. The stimulus drives `flag_clr` exactly on the cycle the count leaves 1, and the flag must read 1 afterwards (R9). The second pair is start and ready arriving together while counting. The count must reload and then keep decrementing, which shows that the access stayed open (R10). A scoreboard queue holds the expected count and flag for every driven cycle, and a monitor compares them one clock later.

// File: rtl/mwd_pkg.sv
package mwd_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD = 2'd0,
    CMD_LOAD = 2'd1,
    CMD_DEC  = 2'd2,
    CMD_ZERO = 2'd3
  } mwd_cmd_e;
endpackage

// File: rtl/mwd_ctrl.sv
module mwd_ctrl
  import mwd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_reload,
  input  logic             acc_start,
  input  logic             mem_ready,
  input  logic [CNT_W-1:0] cnt_q,
  output mwd_cmd_e         cmd,
  output logic             expire,
  output logic             open_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic disabled;
  logic open_d;

  assign disabled = (cfg_reload == '0);

  always_comb begin
    cmd    = CMD_HOLD;
    open_d = open_q;
    if (disabled) begin
      cmd    = CMD_ZERO;
      open_d = 1'b0;
    end else if (acc_start) begin
      cmd    = CMD_LOAD;
      open_d = 1'b1;
    end else if (mem_ready) begin
      cmd    = CMD_LOAD;
      open_d = 1'b0;
    end else if (open_q && cnt_q != '0) begin
      cmd = CMD_DEC;
    end
  end

  assign expire = (cmd == CMD_DEC) && (cnt_q == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end

  // R11: disabled configuration never leaves an access open
  a_r11_no_open_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_reload == '0) |=> !open_q);
  // R10: simultaneous start and ready keeps the access open
  a_r10_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && mem_ready && cfg_reload != '0) |=> open_q);
endmodule

// File: rtl/mwd_counter.sv
module mwd_counter
  import mwd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  mwd_cmd_e         cmd,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      unique case (cmd)
        CMD_LOAD: cnt_q <= load_val;
        CMD_DEC:  cnt_q <= cnt_q - CNT_W'(1);
        CMD_ZERO: cnt_q <= '0;
        default:  cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/mwd_flag.sv
module mwd_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  // R7: sticky without a clear
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);
  // R8: clear takes effect when no set competes
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_q);
  // R9: set beats clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && clr_i) |=> flag_q);
endmodule

// File: rtl/mem_access_wdog.sv
module mem_access_wdog
  import mwd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cfg_reload,
  input  logic             acc_start,
  input  logic             mem_ready,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_val,
  output logic             timeout_flag
);
  mwd_cmd_e         cmd;
  logic             expire;
  logic             open_q;
  logic [CNT_W-1:0] cnt_q;

  mwd_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_reload(cfg_reload),
    .acc_start(acc_start), .mem_ready(mem_ready), .cnt_q(cnt_q),
    .cmd(cmd), .expire(expire), .open_q(open_q)
  );

  mwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .load_val(cfg_reload), .cnt_q(cnt_q)
  );

  mwd_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_i(expire), .clr_i(flag_clr), .flag_q(timeout_flag)
  );

  assign count_val = cnt_q;

  // R2: start loads the reload value
  a_r2_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && cfg_reload != '0) |=> count_val == $past(cfg_reload));
  // R3: ready loads the reload value
  a_r3_ready_load: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ready |=> count_val == $past(cfg_reload));
  // R4: one step down per clock while open
  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && count_val != '0 && !acc_start && !mem_ready && cfg_reload != '0)
    |=> count_val == $past(count_val) - CNT_W'(1));
  // R5: frozen at zero
  a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (count_val == '0 && !acc_start && !mem_ready) |=> count_val == '0);
  // R6: expiry raises the flag
  a_r6_flag_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (open_q && count_val == CNT_W'(1) && !acc_start && !mem_ready && cfg_reload != '0)
    |=> timeout_flag);
  // R11: disabled watchdog never raises the flag
  a_r11_no_flag_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_reload == '0 && !timeout_flag) |=> !timeout_flag);
  // R12: idle count holds
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!open_q && !acc_start && !mem_ready && cfg_reload != '0) |=> $stable(count_val));
endmodule

// File: tb/sim_mem_access_wdog.sv
`timescale 1ns/1ps
module sim_mem_access_wdog;
  localparam int CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [CNT_W-1:0] cfg_reload = 8'd5;
  logic             acc_start = 1'b0;
  logic             mem_ready = 1'b0;
  logic             flag_clr = 1'b0;
  logic [CNT_W-1:0] count_val;
  logic             timeout_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [CNT_W-1:0] cnt;
    logic             flg;
    string            tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  mem_access_wdog #(.CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_reload(cfg_reload),
    .acc_start(acc_start), .mem_ready(mem_ready), .flag_clr(flag_clr),
    .count_val(count_val), .timeout_flag(timeout_flag)
  );

  // driver: applies one cycle of stimulus and queues the expected outcome
  task automatic step(input logic [CNT_W-1:0] cfg, input logic s, input logic r,
                      input logic c, input logic [CNT_W-1:0] ecnt,
                      input logic eflg, input string tag);
    @(negedge clk);
    cfg_reload = cfg;
    acc_start  = s;
    mem_ready  = r;
    flag_clr   = c;
    sb.push_back('{ecnt, eflg, tag});
  endtask

  // monitor: compares one clock after each driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (count_val !== e.cnt || timeout_flag !== e.flg) begin
          failures++;
          $display("FAIL %s: count=%0d flag=%0b expected count=%0d flag=%0b",
                   e.tag, count_val, timeout_flag, e.cnt, e.flg);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, R12 idle hold
    step(5, 0, 0, 0, 0, 0, "R1");
    step(5, 0, 0, 0, 0, 0, "R12");
    // R2 start, R4 countdown, R3 ready ends the access
    step(5, 1, 0, 0, 5, 0, "R2");
    step(5, 0, 0, 0, 4, 0, "R4");
    step(5, 0, 0, 0, 3, 0, "R4");
    step(5, 0, 0, 0, 2, 0, "R4");
    step(5, 0, 1, 0, 5, 0, "R3");
    step(5, 0, 0, 0, 5, 0, "R12");
    step(5, 0, 0, 0, 5, 0, "R12");
    // full timeout: flag exactly 5 clocks after start
    step(5, 1, 0, 0, 5, 0, "R2");
    step(5, 0, 0, 0, 4, 0, "R4");
    step(5, 0, 0, 0, 3, 0, "R4");
    step(5, 0, 0, 0, 2, 0, "R4");
    step(5, 0, 0, 0, 1, 0, "R4");
    step(5, 0, 0, 0, 0, 1, "R6");
    step(5, 0, 0, 0, 0, 1, "R5");
    step(5, 0, 0, 0, 0, 1, "R7");
    step(5, 0, 0, 1, 0, 0, "R8");
    step(5, 0, 0, 0, 0, 0, "R8");
    // restart from frozen zero, expiry collides with clear
    step(5, 1, 0, 0, 5, 0, "R2");
    step(5, 0, 0, 0, 4, 0, "R4");
    step(5, 0, 0, 0, 3, 0, "R4");
    step(5, 0, 0, 0, 2, 0, "R4");
    step(5, 0, 0, 0, 1, 0, "R4");
    step(5, 0, 0, 1, 0, 1, "R9");
    step(5, 0, 0, 1, 0, 0, "R8");
    // start and ready together
    step(5, 1, 0, 0, 5, 0, "R2");
    step(5, 0, 0, 0, 4, 0, "R4");
    step(5, 1, 1, 0, 5, 0, "R10");
    step(5, 0, 0, 0, 4, 0, "R10");
    step(5, 0, 0, 0, 3, 0, "R10");
    step(5, 0, 1, 0, 5, 0, "R3");
    // disabled by zero reload
    step(0, 1, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, "R11");
    step(0, 0, 0, 0, 0, 0, "R11");
    step(0, 1, 1, 0, 0, 0, "R11");
    // short timeout after re-enabling
    step(3, 1, 0, 0, 3, 0, "R2");
    step(3, 0, 0, 0, 2, 0, "R4");
    step(3, 0, 0, 0, 1, 0, "R4");
    step(3, 0, 0, 0, 0, 1, "R6");
    step(3, 0, 0, 0, 0, 1, "R5");
    step(3, 0, 0, 0, 0, 1, "R7");
    step(3, 0, 0, 1, 0, 0, "R8");
    step(3, 0, 0, 0, 0, 0, "R8");
    repeat (3) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #20000;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule